// File: doc/BRIEF.md
# Aliased Microcontroller Register File

This block is the register storage of a small 16-bit microcontroller core. It holds four data registers, two address registers, two stack pointers (one for user code, one for interrupt code), a frame base, a static base and a 20-bit interrupt table base. Two combinational read ports and one clocked write port reach this storage. Each port carries a register selector and a size code. The same bits can therefore be seen as single bytes, as 16-bit words or as 32-bit register pairs.

A stack-select input picks which stack pointer copy the generic stack pointer selector reaches. Both copies also keep their own selectors, so they can always be reached directly. A request whose selector and size do not form a legal view is flagged on that port. Such a request reads as zero, and on the write port it changes nothing.

Selector codes: 0 D0, 1 D1, 2 D2, 3 D3, 4 ADR0, 5 ADR1, 6 USTK, 7 ISTK, 8 STK (banked), 9 FRM, 10 STB, 11 VTAB. Codes 12 to 15 are unused. Size codes: 0 low byte, 1 high byte, 2 word, 3 pair.

Top module: `mcu_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register, so every legal read returns zero afterwards.
- R2: A word write (size 2) to any of D0–D3, ADR0, ADR1, USTK, ISTK, FRM or STB is visible on a word read of that selector from the cycle after the clock edge.
- R3: D0 and D1 accept byte access. Size 0 is bits 7:0 and size 1 is bits 15:8. A byte write takes its value from write-data bits 7:0 and leaves the other byte unchanged. A byte read returns the byte in bits 7:0 with all upper bits zero.
- R4: Pair size on selector 0 gives D2:D0, with D2 in bits 31:16. Pair size on selector 1 gives D3:D1, with D3 in bits 31:16. A pair write updates both halves at the same edge.
- R5: Pair size on selector 4 gives ADR1:ADR0, with ADR1 in the upper half. A pair write updates both halves at the same edge.
- R6: Selector 8 reaches USTK when stack-select is 0 and ISTK when it is 1, for reads and writes. Selectors 6 and 7 reach the two copies directly, whatever stack-select is.
- R7: Byte size on any selector other than 0 or 1, and pair size on any selector other than 0, 1 or 4, is illegal. The port's bad flag goes high, the read data is zero, and a write leaves all storage unchanged. The write bad flag is high only while the write enable is high.
- R8: VTAB (selector 11) is 20 bits wide and takes word size only. A write keeps write-data bits 19:0, and a read returns them zero-extended to 32 bits.
- R9: While the write enable is low, no register changes.
- R10: The two read ports are independent and return identical results for identical requests.
- R11: Selectors 12 to 15 are illegal for every size, on read and write ports alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stk_sel | input | 1 | Stack bank select: 0 user, 1 interrupt |
| rd_a_sel | input | 4 | Read port A selector |
| rd_a_size | input | 2 | Read port A size code |
| rd_a_data | output | 2*DW | Read port A data |
| rd_a_bad | output | 1 | Read port A illegal request |
| rd_b_sel | input | 4 | Read port B selector |
| rd_b_size | input | 2 | Read port B size code |
| rd_b_data | output | 2*DW | Read port B data |
| rd_b_bad | output | 1 | Read port B illegal request |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 4 | Write selector |
| wr_size | input | 2 | Write size code |
| wr_data | input | 2*DW | Write data |
| wr_bad | output | 1 | Illegal write request flagged |

## Verification
The assertions check these properties on every cycle:
- an illegal read returns zero;
- a byte read and a VTAB read leave their upper bits clear;
- nothing changes while writes are disabled;
- both read ports agree on identical requests;
- a legal word write shows up on a matching read one cycle later.

Only the bench's scenarios can show the rest:
- that a byte write leaves the neighbouring byte intact;
- the ordering of halves inside a pair;
- the stack-pointer banking across a change of stack-select;
- that an illegal write really left storage untouched.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int IDXW = 4;
  localparam int NW   = 10;

  localparam logic [3:0] SEL_D0   = 4'd0;
  localparam logic [3:0] SEL_D1   = 4'd1;
  localparam logic [3:0] SEL_D2   = 4'd2;
  localparam logic [3:0] SEL_D3   = 4'd3;
  localparam logic [3:0] SEL_ADR0 = 4'd4;
  localparam logic [3:0] SEL_ADR1 = 4'd5;
  localparam logic [3:0] SEL_USTK = 4'd6;
  localparam logic [3:0] SEL_ISTK = 4'd7;
  localparam logic [3:0] SEL_STK  = 4'd8;
  localparam logic [3:0] SEL_FRM  = 4'd9;
  localparam logic [3:0] SEL_STB  = 4'd10;
  localparam logic [3:0] SEL_VTAB = 4'd11;

  localparam logic [IDXW-1:0] P_D0 = 4'd0;
  localparam logic [IDXW-1:0] P_D1 = 4'd1;
  localparam logic [IDXW-1:0] P_D2 = 4'd2;
  localparam logic [IDXW-1:0] P_D3 = 4'd3;
  localparam logic [IDXW-1:0] P_A0 = 4'd4;
  localparam logic [IDXW-1:0] P_A1 = 4'd5;
  localparam logic [IDXW-1:0] P_US = 4'd6;
  localparam logic [IDXW-1:0] P_IS = 4'd7;
  localparam logic [IDXW-1:0] P_FB = 4'd8;
  localparam logic [IDXW-1:0] P_SB = 4'd9;

  typedef enum logic [1:0] {SZ_BLO = 2'd0, SZ_BHI = 2'd1, SZ_WORD = 2'd2, SZ_PAIR = 2'd3} asize_e;

  typedef struct packed {
    logic            legal;
    logic            vtab;
    asize_e          size;
    logic [IDXW-1:0] lo;
    logic [IDXW-1:0] hi;
  } acc_t;
endpackage

// File: rtl/rf_decode.sv
module rf_decode
  import rf_pkg::*;
(
  input  logic [3:0] sel,
  input  logic [1:0] size,
  input  logic       stk_sel,
  output acc_t       acc
);
  logic is_word;
  logic is_byte;
  assign is_word = (size == SZ_WORD);
  assign is_byte = (size == SZ_BLO) || (size == SZ_BHI);

  always_comb begin
    acc       = '0;
    acc.size  = asize_e'(size);
    case (sel)
      SEL_D0:   begin acc.lo = P_D0; acc.hi = P_D2; acc.legal = 1'b1; end
      SEL_D1:   begin acc.lo = P_D1; acc.hi = P_D3; acc.legal = 1'b1; end
      SEL_D2:   begin acc.lo = P_D2; acc.legal = is_word; end
      SEL_D3:   begin acc.lo = P_D3; acc.legal = is_word; end
      SEL_ADR0: begin acc.lo = P_A0; acc.hi = P_A1; acc.legal = !is_byte; end
      SEL_ADR1: begin acc.lo = P_A1; acc.legal = is_word; end
      SEL_USTK: begin acc.lo = P_US; acc.legal = is_word; end
      SEL_ISTK: begin acc.lo = P_IS; acc.legal = is_word; end
      SEL_STK:  begin acc.lo = stk_sel ? P_IS : P_US; acc.legal = is_word; end
      SEL_FRM:  begin acc.lo = P_FB; acc.legal = is_word; end
      SEL_STB:  begin acc.lo = P_SB; acc.legal = is_word; end
      SEL_VTAB: begin acc.vtab = 1'b1; acc.legal = is_word; end
      default:  acc.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/rf_store.sv
module rf_store
  import rf_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  acc_t                   wacc,
  input  logic [2*DW-1:0]        wdata,
  output logic [NW-1:0][DW-1:0]  words,
  output logic [IW-1:0]          vtab_q
);
  localparam int HB = DW / 2;

  logic do_wr;
  assign do_wr = we && wacc.legal;

  for (genvar i = 0; i < NW; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words[i] <= '0;
      end else if (do_wr && !wacc.vtab) begin
        if (wacc.lo == IDXW'(i)) begin
          case (wacc.size)
            SZ_BLO:  words[i][HB-1:0]  <= wdata[HB-1:0];
            SZ_BHI:  words[i][DW-1:HB] <= wdata[HB-1:0];
            default: words[i]          <= wdata[DW-1:0];
          endcase
        end else if (wacc.size == SZ_PAIR && wacc.hi == IDXW'(i)) begin
          words[i] <= wdata[2*DW-1:DW];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      vtab_q <= '0;
    else if (do_wr && wacc.vtab)  vtab_q <= wdata[IW-1:0];
  end
endmodule

// File: rtl/rf_rdport.sv
module rf_rdport
  import rf_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 20
) (
  input  acc_t                  racc,
  input  logic [NW-1:0][DW-1:0] words,
  input  logic [IW-1:0]         vtab_q,
  output logic [2*DW-1:0]       rdata,
  output logic                  bad
);
  localparam int HB = DW / 2;

  logic [DW-1:0] lo_w;
  logic [DW-1:0] hi_w;
  assign lo_w = words[racc.lo];
  assign hi_w = words[racc.hi];
  assign bad  = !racc.legal;

  always_comb begin
    rdata = '0;
    if (racc.legal) begin
      if (racc.vtab) begin
        rdata[IW-1:0] = vtab_q;
      end else begin
        case (racc.size)
          SZ_BLO:  rdata[HB-1:0] = lo_w[HB-1:0];
          SZ_BHI:  rdata[HB-1:0] = lo_w[DW-1:HB];
          SZ_WORD: rdata[DW-1:0] = lo_w;
          default: rdata         = {hi_w, lo_w};
        endcase
      end
    end
  end
endmodule

// File: rtl/mcu_regfile.sv
module mcu_regfile
  import rf_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stk_sel,
  input  logic [3:0]      rd_a_sel,
  input  logic [1:0]      rd_a_size,
  output logic [2*DW-1:0] rd_a_data,
  output logic            rd_a_bad,
  input  logic [3:0]      rd_b_sel,
  input  logic [1:0]      rd_b_size,
  output logic [2*DW-1:0] rd_b_data,
  output logic            rd_b_bad,
  input  logic            wr_en,
  input  logic [3:0]      wr_sel,
  input  logic [1:0]      wr_size,
  input  logic [2*DW-1:0] wr_data,
  output logic            wr_bad
);
  localparam int NRP = 2;

  logic [NW-1:0][DW-1:0]       words;
  logic [IW-1:0]               vtab_q;
  acc_t                        wacc;
  logic [NRP-1:0][3:0]         rsel;
  logic [NRP-1:0][1:0]         rsize;
  logic [NRP-1:0][2*DW-1:0]    rdat;
  logic [NRP-1:0]              rbad;

  assign rsel  = {rd_b_sel, rd_a_sel};
  assign rsize = {rd_b_size, rd_a_size};
  assign rd_a_data = rdat[0];
  assign rd_b_data = rdat[1];
  assign rd_a_bad  = rbad[0];
  assign rd_b_bad  = rbad[1];

  rf_decode u_wdec (
    .sel     (wr_sel),
    .size    (wr_size),
    .stk_sel (stk_sel),
    .acc     (wacc)
  );

  assign wr_bad = wr_en && !wacc.legal;

  rf_store #(.DW(DW), .IW(IW)) u_store (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_en),
    .wacc   (wacc),
    .wdata  (wr_data),
    .words  (words),
    .vtab_q (vtab_q)
  );

  for (genvar p = 0; p < NRP; p++) begin : g_rp
    acc_t racc;
    rf_decode u_rdec (
      .sel     (rsel[p]),
      .size    (rsize[p]),
      .stk_sel (stk_sel),
      .acc     (racc)
    );
    rf_rdport #(.DW(DW), .IW(IW)) u_rd (
      .racc   (racc),
      .words  (words),
      .vtab_q (vtab_q),
      .rdata  (rdat[p]),
      .bad    (rbad[p])
    );
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rf_pkg::*;
#(
  parameter int DW = 16,
  parameter int IW = 20
) (
  input logic            clk,
  input logic            rst,
  input logic            stk_sel,
  input logic [3:0]      rd_a_sel,
  input logic [1:0]      rd_a_size,
  input logic [2*DW-1:0] rd_a_data,
  input logic            rd_a_bad,
  input logic [3:0]      rd_b_sel,
  input logic [1:0]      rd_b_size,
  input logic [2*DW-1:0] rd_b_data,
  input logic            rd_b_bad,
  input logic            wr_en,
  input logic [3:0]      wr_sel,
  input logic [1:0]      wr_size,
  input logic [2*DW-1:0] wr_data,
  input logic            wr_bad
);
  localparam int HB = DW / 2;

  logic a_same;
  assign a_same = 1'b1;

  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_a_bad |-> rd_a_data == '0); // R7

  AST_WRITE_FLAG_GATED: assert property (@(posedge clk) disable iff (rst)
    wr_bad |-> wr_en); // R7

  AST_BYTE_READ_NARROW: assert property (@(posedge clk) disable iff (rst)
    (!rd_a_bad && (rd_a_size == SZ_BLO || rd_a_size == SZ_BHI)) |-> rd_a_data[2*DW-1:HB] == '0); // R3

  AST_VTAB_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    (rd_a_sel == SEL_VTAB && !rd_a_bad) |-> rd_a_data[2*DW-1:IW] == '0); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (!$stable(rd_a_sel) || !$stable(rd_a_size) || !$stable(stk_sel) || $stable(rd_a_data))); // R9

  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
    (rd_a_sel == rd_b_sel && rd_a_size == rd_b_size) |-> (rd_a_data == rd_b_data && rd_a_bad == rd_b_bad)); // R10

  AST_WORD_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_bad && wr_size == SZ_WORD && wr_sel != SEL_VTAB && rd_a_sel == wr_sel && rd_a_size == SZ_WORD)
    |=> (!$stable(rd_a_sel) || !$stable(rd_a_size) || !$stable(stk_sel) || rd_a_data[DW-1:0] == $past(wr_data[DW-1:0]))); // R2
endmodule

bind mcu_regfile rf_checker #(.DW(DW), .IW(IW)) u_chk (.*);

// File: tb/sim_mcu_regfile.sv
`timescale 1ns/1ps
module sim_mcu_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stk_sel = 1'b0;
  logic [3:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
  logic [1:0]  rd_a_size = 2'd2, rd_b_size = 2'd2, wr_size = 2'd2;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        rd_a_bad, rd_b_bad, wr_bad;
  logic        wr_en = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] ea;
    logic        eab;
    logic [31:0] eb;
    logic        ebb;
    logic        ewb;
    string       req;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  mcu_regfile u0 (
    .clk(clk), .rst(rst), .stk_sel(stk_sel),
    .rd_a_sel(rd_a_sel), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data), .rd_a_bad(rd_a_bad),
    .rd_b_sel(rd_b_sel), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data), .rd_b_bad(rd_b_bad),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data), .wr_bad(wr_bad)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: one access cycle; expectations describe the state after this cycle's edge
  task automatic step(input logic we, input logic [3:0] ws, input logic [1:0] wz, input logic [31:0] wd,
                      input logic [3:0] as, input logic [1:0] az, input logic [3:0] bs, input logic [1:0] bz,
                      input logic stk, input logic [31:0] ea, input logic eab,
                      input logic [31:0] eb, input logic ebb, input logic ewb, input string req);
    item_t it;
    @(negedge clk); #1;
    wr_en = we; wr_sel = ws; wr_size = wz; wr_data = wd;
    rd_a_sel = as; rd_a_size = az; rd_b_sel = bs; rd_b_size = bz; stk_sel = stk;
    it.ea = ea; it.eab = eab; it.eb = eb; it.ebb = ebb; it.ewb = ewb; it.req = req;
    q.push_back(it);
  endtask

  // monitor: samples at the falling edge following each driven cycle
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(rd_a_data, it.ea, it.req, "rd_a_data");
        check({31'd0, rd_a_bad}, {31'd0, it.eab}, it.req, "rd_a_bad");
        check(rd_b_data, it.eb, it.req, "rd_b_data");
        check({31'd0, rd_b_bad}, {31'd0, it.ebb}, it.req, "rd_b_bad");
        check({31'd0, wr_bad}, {31'd0, it.ewb}, it.req, "wr_bad");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // size codes: 0 low byte, 1 high byte, 2 word, 3 pair
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    step(0, 0, 2, 32'h0, 0, 2, 11, 2, 0, 32'h0, 0, 32'h0, 0, 0, "R1");
    step(0, 0, 2, 32'h0, 6, 2, 7, 2, 0, 32'h0, 0, 32'h0, 0, 0, "R1");
    // R2 word write, R3 byte views
    step(1, 0, 2, 32'h1234, 0, 2, 0, 1, 0, 32'h1234, 0, 32'h12, 0, 0, "R2");
    step(1, 0, 0, 32'hFFAB, 0, 2, 0, 0, 0, 32'h12AB, 0, 32'hAB, 0, 0, "R3");
    step(1, 1, 1, 32'h00C5, 1, 2, 1, 0, 0, 32'hC500, 0, 32'h00, 0, 0, "R3");
    // R4 pairs
    step(1, 2, 2, 32'hBEEF, 0, 3, 2, 2, 0, 32'hBEEF12AB, 0, 32'hBEEF, 0, 0, "R4");
    step(1, 1, 3, 32'h89ABCDEF, 3, 2, 1, 2, 0, 32'h89AB, 0, 32'hCDEF, 0, 0, "R4");
    // R5 address pair
    step(1, 4, 3, 32'h11112222, 5, 2, 4, 2, 0, 32'h1111, 0, 32'h2222, 0, 0, "R5");
    step(0, 0, 2, 32'h0, 4, 3, 5, 2, 0, 32'h11112222, 0, 32'h1111, 0, 0, "R5");
    // R6 banked stack pointer
    step(1, 8, 2, 32'h0400, 6, 2, 8, 2, 0, 32'h0400, 0, 32'h0400, 0, 0, "R6");
    step(1, 8, 2, 32'h0800, 7, 2, 6, 2, 1, 32'h0800, 0, 32'h0400, 0, 0, "R6");
    step(0, 0, 2, 32'h0, 8, 2, 7, 2, 1, 32'h0800, 0, 32'h0800, 0, 0, "R6");
    step(0, 0, 2, 32'h0, 8, 2, 7, 2, 0, 32'h0400, 0, 32'h0800, 0, 0, "R6");
    // R2 frame and static base
    step(1, 9, 2, 32'h7777, 9, 2, 10, 2, 0, 32'h7777, 0, 32'h0, 0, 0, "R2");
    step(1, 10, 2, 32'h5A5A, 10, 2, 9, 2, 0, 32'h5A5A, 0, 32'h7777, 0, 0, "R2");
    // R8 vector table base
    step(1, 11, 2, 32'hFFFFFFFF, 11, 2, 3, 2, 0, 32'h000FFFFF, 0, 32'h89AB, 0, 0, "R8");
    // R7 illegal requests
    step(1, 2, 0, 32'h0055, 2, 2, 2, 0, 0, 32'hBEEF, 0, 32'h0, 1, 1, "R7");
    step(1, 9, 3, 32'hDEAD0000, 9, 2, 9, 3, 0, 32'h7777, 0, 32'h0, 1, 1, "R7");
    step(1, 11, 0, 32'h0, 11, 2, 11, 1, 0, 32'h000FFFFF, 0, 32'h0, 1, 1, "R7");
    // R11 unused selectors
    step(1, 13, 2, 32'h9999, 0, 2, 12, 2, 0, 32'h12AB, 0, 32'h0, 1, 1, "R11");
    step(0, 0, 2, 32'h0, 15, 3, 1, 2, 0, 32'h0, 1, 32'hCDEF, 0, 0, "R11");
    // R9 write disabled
    step(0, 0, 2, 32'h9999, 0, 2, 0, 1, 0, 32'h12AB, 0, 32'h12, 0, 0, "R9");
    // R10 identical requests on both ports
    step(0, 0, 2, 32'h0, 1, 3, 1, 3, 0, 32'h89ABCDEF, 0, 32'h89ABCDEF, 0, 0, "R10");
    // R3 low byte of D1 inside its pair
    step(1, 1, 0, 32'h0034, 1, 3, 1, 1, 0, 32'h89ABCD34, 0, 32'hCD, 0, 0, "R3");
    // R1 reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); #1; rst = 1'b0; wr_en = 1'b0;
    step(0, 0, 2, 32'h0, 1, 3, 11, 2, 0, 32'h0, 0, 32'h0, 0, 0, "R1");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule